// File: doc/BRIEF.md
# Ternary Digit Adder

This block adds two words of ternary digits, where each digit travels on a pair of binary wires. The digit codes are 00 for zero, 01 for one and 10 for two; the pattern 11 is never a legal digit. The block is purely combinational. Every output follows its inputs within the same cycle, with no register and no handshake.

The first stage can be a half-adder, which takes two digits and returns a sum digit and a single binary carry. It can also be a full-adder stage, which accepts a binary carry-in as well. Further full-adder stages ripple the carry from the least significant digit upward, so the block handles a word of `DIGITS` digits. The sum and carry equations are minimised by treating the unused code as a don't-care. A separate detector raises a flag whenever any input digit carries the unused code. While that flag is high, the sum and carry outputs carry no meaning.

Top module: `tern_ripple_add`

## Requirements
- R1: Each digit occupies two bits at bit positions [2i+1:2i] of its word, with digit 0 least significant. The codes are 00 = 0, 01 = 1 and 10 = 2; the code 11 is illegal.
- R2: With `HAS_CIN` = 0, digit 0 of `sum_o` is (A0 + B0) mod 3.
- R3: With `HAS_CIN` = 0, the carry out of digit 0 is 1 exactly when A0 + B0 is 3 or more, that is for 1+2, 2+1 and 2+2.
- R4: For legal inputs, no sum digit ever carries the code 11. For example, 2+2 gives sum code 01 with carry 1.
- R5: A full-adder stage gives the sum digit (A + B + carry-in) mod 3, and its carry-out is 1 when that total is 3 or more.
- R6: Carries ripple from digit i to digit i+1. For legal inputs, value(sum_o) + 3^DIGITS · cout_o equals value(a_i) + value(b_i) + cin_i. Here cin_i counts only when `HAS_CIN` = 1.
- R7: `invalid_o` is 1 exactly when at least one digit of `a_i` or `b_i` is 11.
- R8: With `HAS_CIN` = 0, `cin_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 2*DIGITS | First operand, packed ternary digits |
| b_i | input | 2*DIGITS | Second operand, packed ternary digits |
| cin_i | input | 1 | Binary carry into digit 0 (used only when HAS_CIN = 1) |
| sum_o | output | 2*DIGITS | Sum, packed ternary digits |
| cout_o | output | 1 | Carry out of the most significant digit |
| invalid_o | output | 1 | High when any input digit has the code 11 |

## Verification
The embedded assertions run on every evaluation whenever the inputs are legal. In each stage they confirm that three times the carry plus the sum digit equals the stage's arithmetic total, and that no sum digit takes the unused code. At the top they also check the whole word total. Some behaviours only the bench scenarios can show. One is that the carry-in is ignored when the half-adder head is selected. Others are that the invalid flag responds to a bad code in every digit position, and that a carry ripples correctly across the full word, as in 80 + 0 + 1 producing all zero digits with a carry-out. The bench exhaustively sweeps all legal operand pairs for the half and full stages and compares against integer arithmetic.

// File: rtl/tern_pkg.sv
`timescale 1ns/1ps
package tern_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_ZERO = 2'b00;
  localparam trit_t TRIT_ONE  = 2'b01;
  localparam trit_t TRIT_TWO  = 2'b10;
  localparam trit_t TRIT_BAD  = 2'b11;

  // the code's binary value equals the digit value for legal codes
  function automatic int trit_val(trit_t t);
    return int'(t);
  endfunction

  function automatic logic trit_ok(trit_t t);
    return t != TRIT_BAD;
  endfunction

  function automatic longint pow3(int n);
    longint r;
    r = 1;
    for (int k = 0; k < n; k++) r = r * 3;
    return r;
  endfunction
endpackage

// File: rtl/tern_code_chk.sv
`timescale 1ns/1ps
module tern_code_chk
  import tern_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [2*N-1:0] codes_i,
  output logic           bad_o
);
  logic [N-1:0] flag;

  for (genvar i = 0; i < N; i++) begin : g_dig
    assign flag[i] = codes_i[2*i+1] & codes_i[2*i];
  end

  assign bad_o = |flag;
endmodule

// File: rtl/tern_half_add.sv
`timescale 1ns/1ps
module tern_half_add
  import tern_pkg::*;
(
  input  trit_t a_i,
  input  trit_t b_i,
  output trit_t sum_o,
  output logic  carry_o
);
  // minimised with code 11 as don't-care
  always_comb begin
    carry_o  = (a_i[0] & b_i[1]) | (a_i[1] & b_i[1]) | (a_i[1] & b_i[0]);
    sum_o[1] = (~a_i[1] & ~a_i[0] & b_i[1]) | (a_i[0] & b_i[0])
             | (a_i[1] & ~b_i[1] & ~b_i[0]);
    sum_o[0] = (~a_i[1] & ~a_i[0] & b_i[0]) | (a_i[1] & b_i[1])
             | (a_i[0] & ~b_i[1] & ~b_i[0]);
  end

  always_comb begin
    if (trit_ok(a_i) && trit_ok(b_i)) begin
      // R4
      ha_sum_code_chk: assert (trit_ok(sum_o));
      // R2 R3
      ha_total_chk: assert (3 * int'(carry_o) + trit_val(sum_o)
                            == trit_val(a_i) + trit_val(b_i));
    end
  end
endmodule

// File: rtl/tern_full_add.sv
`timescale 1ns/1ps
module tern_full_add
  import tern_pkg::*;
(
  input  trit_t a_i,
  input  trit_t b_i,
  input  logic  carry_i,
  output trit_t sum_o,
  output logic  carry_o
);
  trit_t pair_sum;
  logic  pair_carry;

  tern_half_add u_pair (
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_o  (pair_sum),
    .carry_o(pair_carry)
  );

  // a carry-in increments the pair sum: 00->01, 01->10, 10->00 with carry
  assign sum_o[1] = carry_i ? pair_sum[0] : pair_sum[1];
  assign sum_o[0] = carry_i ? (~pair_sum[1] & ~pair_sum[0]) : pair_sum[0];
  assign carry_o  = pair_carry | (carry_i & pair_sum[1]);

  always_comb begin
    if (trit_ok(a_i) && trit_ok(b_i)) begin
      // R4
      fa_sum_code_chk: assert (trit_ok(sum_o));
      // R5
      fa_total_chk: assert (3 * int'(carry_o) + trit_val(sum_o)
                            == trit_val(a_i) + trit_val(b_i) + int'(carry_i));
    end
  end
endmodule

// File: rtl/tern_ripple_add.sv
`timescale 1ns/1ps
module tern_ripple_add
  import tern_pkg::*;
#(
  parameter int DIGITS  = 4,
  parameter bit HAS_CIN = 1'b1
) (
  input  logic [2*DIGITS-1:0] a_i,
  input  logic [2*DIGITS-1:0] b_i,
  input  logic                cin_i,
  output logic [2*DIGITS-1:0] sum_o,
  output logic                cout_o,
  output logic                invalid_o
);
  localparam int     W     = 2 * DIGITS;
  localparam longint WORD_SPAN = pow3(DIGITS);

  logic [DIGITS:0] chain;

  assign chain[0] = cin_i & HAS_CIN;

  for (genvar i = 0; i < DIGITS; i++) begin : g_stage
    if (i == 0 && !HAS_CIN) begin : g_head
      logic unused_head;
      assign unused_head = chain[0];
      tern_half_add u_ha (
        .a_i    (a_i[2*i +: 2]),
        .b_i    (b_i[2*i +: 2]),
        .sum_o  (sum_o[2*i +: 2]),
        .carry_o(chain[i+1])
      );
    end else begin : g_full
      tern_full_add u_fa (
        .a_i    (a_i[2*i +: 2]),
        .b_i    (b_i[2*i +: 2]),
        .carry_i(chain[i]),
        .sum_o  (sum_o[2*i +: 2]),
        .carry_o(chain[i+1])
      );
    end
  end

  assign cout_o = chain[DIGITS];

  tern_code_chk #(.N(2 * DIGITS)) u_chk (
    .codes_i({b_i, a_i}),
    .bad_o  (invalid_o)
  );

  function automatic longint word_val(logic [W-1:0] w);
    longint acc;
    acc = 0;
    for (int k = DIGITS - 1; k >= 0; k--) acc = acc * 3 + longint'(w[2*k +: 2]);
    return acc;
  endfunction

  function automatic logic word_legal(logic [W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIGITS; k++) if (w[2*k +: 2] == TRIT_BAD) ok = 1'b0;
    return ok;
  endfunction

  always_comb begin
    if (!invalid_o) begin
      // R4
      word_code_chk: assert (word_legal(sum_o));
      // R6
      word_total_chk: assert (word_val(sum_o) + WORD_SPAN * longint'(cout_o)
                              == word_val(a_i) + word_val(b_i)
                                 + longint'(cin_i & HAS_CIN));
    end
  end
endmodule

// File: tb/sim_tern_ripple_add.sv
`timescale 1ns/1ps
module sim_tern_ripple_add;
  localparam int D    = 4;
  localparam int SPAN = 81;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2*D-1:0] a, b;
  logic           cin;
  logic [2*D-1:0] sum;
  logic           cout, inv;

  logic [1:0] ha_a, ha_b;
  logic       ha_cin;
  logic [1:0] ha_s;
  logic       ha_c, ha_inv;

  tern_ripple_add #(.DIGITS(D), .HAS_CIN(1'b1)) u0 (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout), .invalid_o(inv)
  );

  tern_ripple_add #(.DIGITS(1), .HAS_CIN(1'b0)) u1 (
    .a_i(ha_a), .b_i(ha_b), .cin_i(ha_cin), .sum_o(ha_s), .cout_o(ha_c),
    .invalid_o(ha_inv)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [2*D-1:0] to_word(int v);
    logic [2*D-1:0] w;
    for (int k = 0; k < D; k++) begin
      w[2*k +: 2] = 2'(v % 3);
      v = v / 3;
    end
    return w;
  endfunction

  function automatic int from_word(logic [2*D-1:0] w);
    int acc = 0;
    for (int k = D - 1; k >= 0; k--) acc = acc * 3 + int'(w[2*k +: 2]);
    return acc;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model for the multi-digit adder, checked one cycle per stimulus
  task automatic word_step(int x, int y, int c);
    int tot;
    @(posedge clk);
    a = to_word(x); b = to_word(y); cin = c[0];
    @(negedge clk);
    tot = x + y + c;
    chk("R6 word sum", from_word(sum), tot % SPAN);
    chk("R6 carry-out", int'(cout), int'(tot >= SPAN));
    chk("R7 flag low", int'(inv), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    ha_a = '0; ha_b = '0; ha_cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle sum", int'(sum), 0);
    chk("R1 idle carry", int'(cout), 0);
    chk("R7 idle flag", int'(inv), 0);

    // half-adder head: all legal pairs, both carry-in values (ignored)
    for (int x = 0; x < 3; x++)
      for (int y = 0; y < 3; y++)
        for (int c = 0; c < 2; c++) begin
          @(posedge clk);
          ha_a = 2'(x); ha_b = 2'(y); ha_cin = c[0];
          @(negedge clk);
          chk("R2 R8 half sum", int'(ha_s), (x + y) % 3);
          chk("R3 R8 half carry", int'(ha_c), int'(x + y >= 3));
          chk("R4 half code legal", int'(ha_s != 2'b11), 1);
          chk("R7 half flag", int'(ha_inv), 0);
        end

    // 2+2 gives code 01 with carry
    @(posedge clk); ha_a = 2'b10; ha_b = 2'b10; ha_cin = 1'b0;
    @(negedge clk);
    chk("R4 two plus two code", int'(ha_s), 1);
    chk("R3 two plus two carry", int'(ha_c), 1);

    // full stage: all legal digit pairs and carry-in on digit 0
    for (int x = 0; x < 3; x++)
      for (int y = 0; y < 3; y++)
        for (int c = 0; c < 2; c++) begin
          @(posedge clk);
          a = to_word(x); b = to_word(y); cin = c[0];
          @(negedge clk);
          chk("R5 full sum digit", int'(sum[1:0]), (x + y + c) % 3);
          chk("R5 full carry into digit1", int'(sum[3:2]), (x + y + c) / 3);
          chk("R4 full code legal", int'(sum[1:0] != 2'b11), 1);
        end

    // ripple boundaries
    word_step(SPAN - 1, 0, 1);
    word_step(SPAN - 1, SPAN - 1, 1);
    word_step(SPAN - 1, SPAN - 1, 0);
    word_step(40, 40, 1);
    word_step(1, 1, 1);

    for (int n = 0; n < 200; n++)
      word_step($urandom_range(SPAN - 1), $urandom_range(SPAN - 1),
                $urandom_range(1));

    // invalid code in every digit position of each operand
    for (int p = 0; p < D; p++) begin
      @(posedge clk);
      a = to_word(0); b = to_word(0); cin = 1'b0;
      a[2*p +: 2] = 2'b11;
      @(negedge clk);
      chk("R7 bad digit in a", int'(inv), 1);
      @(posedge clk);
      a = to_word(0); b[2*p +: 2] = 2'b11;
      @(negedge clk);
      chk("R7 bad digit in b", int'(inv), 1);
    end
    @(posedge clk); ha_a = 2'b11; ha_b = 2'b00;
    @(negedge clk);
    chk("R7 half bad code", int'(ha_inv), 1);
    @(posedge clk); ha_a = 2'b01; ha_b = 2'b01; a = '0; b = '0;
    @(negedge clk);
    chk("R7 flag clears", int'(ha_inv), 0);
    chk("R7 word flag clears", int'(inv), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule